// File: doc/BRIEF.md
# Move Instruction Decoder and Address Generator

This block decodes one 16-bit data-move instruction word per clock and produces everything a single execution step needs. It works out the effective memory address and the access size, and whether the access is a load or a store. It supplies the store data, the register to write back, and any change to a base register. It also sign-extends immediates and narrow load data before writeback. The register file lives outside the block. It returns the register named by bits [11:8] of the word on `fa_data`, the register named by bits [7:4] on `fb_data`, and register 0 on `r0_data`, all in the same cycle as the word.

The word, PC and operands are sampled on a rising clock edge while `instr_vld` is high. The decoded controls appear from the register stage on the following cycle. While that cycle is current, memory returns the read data on `mem_rdata` for the presented address. The block extends that data by access size and sends it out on `wb_data`. Words that match no supported move encoding raise `illegal`, and no memory access or register write takes place for them.

Top module: `mv_move_unit`

## Requirements
- R1: While `rst` is high, and in any cycle that follows a clock edge where `instr_vld` was low, `illegal`, `mem_req`, `wb_en` and `upd_en` are all low. The outputs for a word sampled at edge k are valid from edge k until edge k+1.
- R2: A word of the form 1110 nnnn iiii iiii writes the 8-bit immediate, sign-extended to 32 bits, into register n. It makes no memory access.
- R3: The forms 1001 nnnn dddddddd and 1101 nnnn dddddddd load into register n from PC plus the unsigned displacement times 2 (word size) or times 4 (long size).
- R4: The form 0110 nnnn mmmm 0011 copies `fb_data` into register n. It makes no memory access.
- R5: Size codes on `mem_size` are 0 for byte, 1 for word and 2 for long. With prefix 0110, low nibble 00ss loads register n from the address in register m. With prefix 0010, low nibble 00ss stores register m to the address in register n. ss is the size code, and 11 is illegal. Store data is register m with the bits above the access size cleared.
- R6: Prefix 0010 with low nibble 01ss is a pre-decrement store. The address is register n minus 1, 2 or 4 for byte, word or long. Register n is updated to that same address through `upd_en`, `upd_idx` and `upd_data`.
- R7: Prefix 0110 with low nibble 01ss is a post-increment load. It reads from the old register m and updates register m to that address plus 1, 2 or 4. When m equals n, only the loaded data is written, and `upd_en` stays low.
- R8: Byte and word load data are sign-extended from bit 7 or bit 15 onto `wb_data`. Long load data passes through unchanged.
- R9: With upper byte 1000 0000 or 1000 0001 and low byte nnnn dddd, register 0 is stored at register n plus d (byte) or plus d×2 (word). With upper byte 1000 0100 or 1000 0101 and low byte mmmm dddd, register 0 is loaded from register m plus d or plus d×2.
- R10: The form 0001 nnnn mmmm dddd stores register m as a long at register n plus d×4. The form 0101 nnnn mmmm dddd loads a long from register m plus d×4 into register n. d is an unsigned 4-bit value.
- R11: Prefix 0000 with low nibble 01ss stores register m at the address `r0_data` plus register n, with size ss.
- R12: Any valid word outside the forms above raises `illegal` for one cycle, and `mem_req`, `wb_en` and `upd_en` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| instr_vld | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 16 | Instruction word |
| pc | input | 32 | Address of the current instruction |
| fa_data | input | 32 | Register selected by instr[11:8] |
| fb_data | input | 32 | Register selected by instr[7:4] |
| r0_data | input | 32 | Register 0 |
| mem_rdata | input | 32 | Memory read data for the presented address |
| illegal | output | 1 | Word matched no supported encoding |
| mem_req | output | 1 | Memory access requested |
| mem_we | output | 1 | 1 for store, 0 for load |
| mem_size | output | 2 | 0 byte, 1 word, 2 long |
| mem_addr | output | 32 | Effective address |
| mem_wdata | output | 32 | Store data, zero above the access size |
| wb_en | output | 1 | Write a result register |
| wb_idx | output | 4 | Result register index |
| wb_data | output | 32 | Result value, sign-extended where required |
| upd_en | output | 1 | Write back a changed base register |
| upd_idx | output | 4 | Base register index |
| upd_data | output | 32 | New base register value |

## Verification
Two results can come out in the same cycle: the loaded value on the writeback port and the changed base register on the update port. This happens for post-increment loads, and for pre-decrement stores, where the update coincides with the store itself. Every one of the 65,536 instruction words is applied, so the sweep covers every register pairing. That includes the post-increment words where m equals n, where only the load result may be written. For each word the bench works out the address, step and extended data arithmetically and compares both ports in the following cycle. Checker properties require that two simultaneous writes never target the same index. They also require that the update value differs from the presented address by either zero or exactly the access size.

// File: rtl/mvdec_pkg.sv
package mvdec_pkg;

    localparam int unsigned XW  = 32;   // datapath width
    localparam int unsigned IXW = 4;    // register index width
    localparam int unsigned IW  = 16;   // instruction width

    typedef enum logic [1:0] {
        SZ_B = 2'd0,
        SZ_W = 2'd1,
        SZ_L = 2'd2
    } msize_e;

    typedef struct packed {
        logic             legal;
        logic             req;
        logic             we;
        msize_e           sz;
        logic [XW-1:0]    addr;
        logic [XW-1:0]    wdata;
        logic             wb;
        logic [IXW-1:0]   wb_idx;
        logic             wb_mem;
        logic [XW-1:0]    wb_val;
        logic             upd;
        logic [IXW-1:0]   upd_idx;
        logic [XW-1:0]    upd_val;
    } mv_ctl_t;

    function automatic logic [XW-1:0] step_of(msize_e s);
        return XW'(1) << s;
    endfunction

    function automatic logic [XW-1:0] sext_to(logic [XW-1:0] v, msize_e s);
        case (s)
            SZ_B:    return {{(XW-8){v[7]}}, v[7:0]};
            SZ_W:    return {{(XW-16){v[15]}}, v[15:0]};
            default: return v;
        endcase
    endfunction

    function automatic logic [XW-1:0] clip_to(logic [XW-1:0] v, msize_e s);
        case (s)
            SZ_B:    return {{(XW-8){1'b0}}, v[7:0]};
            SZ_W:    return {{(XW-16){1'b0}}, v[15:0]};
            default: return v;
        endcase
    endfunction

endpackage

// File: rtl/mv_field_decode.sv
module mv_field_decode
    import mvdec_pkg::*;
(
    input  logic [IW-1:0]  instr,
    input  logic [XW-1:0]  pc,
    input  logic [XW-1:0]  fa,
    input  logic [XW-1:0]  fb,
    input  logic [XW-1:0]  r0,
    output mv_ctl_t        ctl
);
    logic [IXW-1:0] nf, mf;
    logic [3:0]     lo;
    logic [7:0]     d8;
    logic [XW-1:0]  d4x;
    msize_e         lsz;
    logic           lsz_ok;

    assign nf     = instr[11:8];
    assign mf     = instr[7:4];
    assign lo     = instr[3:0];
    assign d8     = instr[7:0];
    assign d4x    = XW'(lo);
    assign lsz    = msize_e'(lo[1:0]);
    assign lsz_ok = (lo[1:0] != 2'b11);

    always_comb begin
        ctl    = '0;
        ctl.sz = SZ_B;
        unique case (instr[15:12])
            4'hE: begin
                ctl.legal  = 1'b1;
                ctl.wb     = 1'b1;
                ctl.wb_idx = nf;
                ctl.wb_val = sext_to(XW'(d8), SZ_B);
            end
            4'h9, 4'hD: begin
                ctl.legal  = 1'b1;
                ctl.req    = 1'b1;
                ctl.sz     = instr[14] ? SZ_L : SZ_W;
                ctl.addr   = pc + (XW'(d8) << (instr[14] ? 2 : 1));
                ctl.wb     = 1'b1;
                ctl.wb_idx = nf;
                ctl.wb_mem = 1'b1;
            end
            4'h6: begin
                if (lo == 4'b0011) begin
                    ctl.legal  = 1'b1;
                    ctl.wb     = 1'b1;
                    ctl.wb_idx = nf;
                    ctl.wb_val = fb;
                end else if (lsz_ok && lo[3] == 1'b0) begin
                    ctl.legal  = 1'b1;
                    ctl.req    = 1'b1;
                    ctl.sz     = lsz;
                    ctl.addr   = fb;
                    ctl.wb     = 1'b1;
                    ctl.wb_idx = nf;
                    ctl.wb_mem = 1'b1;
                    // post-increment: loaded data wins when m == n
                    ctl.upd     = lo[2] && (mf != nf);
                    ctl.upd_idx = mf;
                    ctl.upd_val = fb + step_of(lsz);
                end
            end
            4'h2: begin
                if (lsz_ok && lo[3] == 1'b0) begin
                    ctl.legal   = 1'b1;
                    ctl.req     = 1'b1;
                    ctl.we      = 1'b1;
                    ctl.sz      = lsz;
                    ctl.addr    = lo[2] ? fa - step_of(lsz) : fa;
                    ctl.wdata   = clip_to(fb, lsz);
                    ctl.upd     = lo[2];
                    ctl.upd_idx = nf;
                    ctl.upd_val = fa - step_of(lsz);
                end
            end
            4'h8: begin
                if (nf == 4'h0 || nf == 4'h1 || nf == 4'h4 || nf == 4'h5) begin
                    ctl.legal  = 1'b1;
                    ctl.req    = 1'b1;
                    ctl.we     = ~nf[2];
                    ctl.sz     = nf[0] ? SZ_W : SZ_B;
                    ctl.addr   = fb + (d4x << nf[0]);
                    ctl.wdata  = clip_to(r0, nf[0] ? SZ_W : SZ_B);
                    ctl.wb     = nf[2];
                    ctl.wb_idx = '0;
                    ctl.wb_mem = 1'b1;
                end
            end
            4'h1: begin
                ctl.legal = 1'b1;
                ctl.req   = 1'b1;
                ctl.we    = 1'b1;
                ctl.sz    = SZ_L;
                ctl.addr  = fa + (d4x << 2);
                ctl.wdata = fb;
            end
            4'h5: begin
                ctl.legal  = 1'b1;
                ctl.req    = 1'b1;
                ctl.sz     = SZ_L;
                ctl.addr   = fb + (d4x << 2);
                ctl.wb     = 1'b1;
                ctl.wb_idx = nf;
                ctl.wb_mem = 1'b1;
            end
            4'h0: begin
                if (lsz_ok && lo[3:2] == 2'b01) begin
                    ctl.legal = 1'b1;
                    ctl.req   = 1'b1;
                    ctl.we    = 1'b1;
                    ctl.sz    = lsz;
                    ctl.addr  = r0 + fa;
                    ctl.wdata = clip_to(fb, lsz);
                end
            end
            default: ctl.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/mv_load_extend.sv
module mv_load_extend
    import mvdec_pkg::*;
(
    input  msize_e         sz,
    input  logic [XW-1:0]  raw,
    output logic [XW-1:0]  ext
);
    assign ext = sext_to(raw, sz);
endmodule

// File: rtl/mv_move_unit.sv
module mv_move_unit
    import mvdec_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                instr_vld,
    input  logic [15:0]         instr,
    input  logic [31:0]         pc,
    input  logic [31:0]         fa_data,
    input  logic [31:0]         fb_data,
    input  logic [31:0]         r0_data,
    input  logic [31:0]         mem_rdata,
    output logic                illegal,
    output logic                mem_req,
    output logic                mem_we,
    output logic [1:0]          mem_size,
    output logic [31:0]         mem_addr,
    output logic [31:0]         mem_wdata,
    output logic                wb_en,
    output logic [3:0]          wb_idx,
    output logic [31:0]         wb_data,
    output logic                upd_en,
    output logic [3:0]          upd_idx,
    output logic [31:0]         upd_data
);
    mv_ctl_t       dec_c, ctl_q;
    logic          ill_q;
    logic [XW-1:0] ld_ext;

    mv_field_decode u_dec (
        .instr (instr),
        .pc    (pc),
        .fa    (fa_data),
        .fb    (fb_data),
        .r0    (r0_data),
        .ctl   (dec_c)
    );

    always_ff @(posedge clk) begin
        if (rst || !instr_vld) begin
            ctl_q  <= '0;
            ill_q  <= 1'b0;
        end else begin
            ctl_q  <= dec_c;
            ill_q  <= ~dec_c.legal;
        end
    end

    mv_load_extend u_ext (
        .sz  (ctl_q.sz),
        .raw (mem_rdata),
        .ext (ld_ext)
    );

    assign illegal   = ill_q;
    assign mem_req   = ctl_q.req;
    assign mem_we    = ctl_q.we;
    assign mem_size  = ctl_q.sz;
    assign mem_addr  = ctl_q.addr;
    assign mem_wdata = ctl_q.wdata;
    assign wb_en     = ctl_q.wb;
    assign wb_idx    = ctl_q.wb_idx;
    assign wb_data   = ctl_q.wb_mem ? ld_ext : ctl_q.wb_val;
    assign upd_en    = ctl_q.upd;
    assign upd_idx   = ctl_q.upd_idx;
    assign upd_data  = ctl_q.upd_val;
endmodule

// File: rtl/mv_move_checker.sv
module mv_move_checker (
    input logic        clk,
    input logic        rst,
    input logic        instr_vld,
    input logic        illegal,
    input logic        mem_req,
    input logic        mem_we,
    input logic [1:0]  mem_size,
    input logic [31:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic        wb_en,
    input logic [3:0]  wb_idx,
    input logic [31:0] wb_data,
    input logic        upd_en,
    input logic [3:0]  upd_idx,
    input logic [31:0] upd_data
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(instr_vld) |-> !(illegal || mem_req || wb_en || upd_en));

    p_illegal_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !(mem_req || wb_en || upd_en));

    p_size_code_r5: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> mem_size != 2'b11);

    p_byte_store_clip_r5: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_size == 2'd0) |-> mem_wdata[31:8] == 24'd0);

    p_update_has_access_r6: assert property (@(posedge clk) disable iff (rst)
        upd_en |-> mem_req);

    p_update_step_r7: assert property (@(posedge clk) disable iff (rst)
        upd_en |-> (upd_data == mem_addr) ||
                   (upd_data == mem_addr + (32'd1 << mem_size)));

    p_no_dual_target_r7: assert property (@(posedge clk) disable iff (rst)
        (upd_en && wb_en) |-> upd_idx != wb_idx);

    p_byte_load_sext_r8: assert property (@(posedge clk) disable iff (rst)
        (wb_en && mem_req && !mem_we && mem_size == 2'd0)
            |-> wb_data[31:8] == {24{wb_data[7]}});

    p_store_no_wb_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we) |-> !wb_en);
endmodule

bind mv_move_unit mv_move_checker chk (.*);

// File: tb/mv_move_unit_test.sv
module mv_move_unit_test;
    localparam int CLK_NS = 10;
    localparam int WDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst;
    logic        instr_vld;
    logic [15:0] instr;
    logic [31:0] pc, fa_data, fb_data, r0_data, mem_rdata;
    logic        illegal, mem_req, mem_we, wb_en, upd_en;
    logic [1:0]  mem_size;
    logic [31:0] mem_addr, mem_wdata, wb_data, upd_data;
    logic [3:0]  wb_idx, upd_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    // memory model: data is a fixed function of the address
    function automatic logic [31:0] mem_fn(logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h0080_8080;
    endfunction
    assign mem_rdata = mem_fn(mem_addr);

    mv_move_unit uut (.*);

    // expected values
    logic        e_ill, e_req, e_we, e_wb, e_upd;
    logic [1:0]  e_sz;
    logic [31:0] e_addr, e_wd, e_wbd, e_updd;
    logic [3:0]  e_wbi, e_updi;
    string       e_tag;

    function automatic logic [31:0] ext_b(logic [31:0] v, logic [1:0] s);
        if (s == 2'd0) return {{24{v[7]}}, v[7:0]};
        if (s == 2'd1) return {{16{v[15]}}, v[15:0]};
        return v;
    endfunction
    function automatic logic [31:0] msk(logic [31:0] v, logic [1:0] s);
        if (s == 2'd0) return v & 32'hFF;
        if (s == 2'd1) return v & 32'hFFFF;
        return v;
    endfunction

    task automatic predict(input logic [15:0] w, input logic [31:0] p,
                           input logic [31:0] a, input logic [31:0] b,
                           input logic [31:0] z);
        logic [3:0]  n  = w[11:8];
        logic [3:0]  m  = w[7:4];
        logic [1:0]  s  = w[1:0];
        int unsigned st = 1 << w[1:0];
        logic        ld = 1'b0;
        e_ill = 0; e_req = 0; e_we = 0; e_wb = 0; e_upd = 0; e_sz = 0;
        e_addr = 0; e_wd = 0; e_wbd = 0; e_updd = 0; e_wbi = 0; e_updi = 0;
        e_tag = "R12";
        casez (w)
            16'b1110_????_????_????: begin
                e_tag = "R2"; e_wb = 1; e_wbi = n;
                e_wbd = {{24{w[7]}}, w[7:0]};
            end
            16'b1001_????_????_????: begin
                e_tag = "R3"; e_req = 1; e_sz = 1; ld = 1; e_wbi = n;
                e_addr = p + 32'(w[7:0]) * 2;
            end
            16'b1101_????_????_????: begin
                e_tag = "R3"; e_req = 1; e_sz = 2; ld = 1; e_wbi = n;
                e_addr = p + 32'(w[7:0]) * 4;
            end
            16'b0110_????_????_0011: begin
                e_tag = "R4"; e_wb = 1; e_wbi = n; e_wbd = b;
            end
            16'b0110_????_????_00??: begin
                e_tag = "R5"; e_req = 1; e_sz = s; ld = 1; e_wbi = n;
                e_addr = b;
            end
            16'b0110_????_????_01??: if (s != 3) begin
                e_tag = "R7"; e_req = 1; e_sz = s; ld = 1; e_wbi = n;
                e_addr = b;
                e_upd = (m != n); e_updi = m; e_updd = b + st;
            end
            16'b0010_????_????_00??: if (s != 3) begin
                e_tag = "R5"; e_req = 1; e_we = 1; e_sz = s;
                e_addr = a; e_wd = msk(b, s);
            end
            16'b0010_????_????_01??: if (s != 3) begin
                e_tag = "R6"; e_req = 1; e_we = 1; e_sz = s;
                e_addr = a - st; e_wd = msk(b, s);
                e_upd = 1; e_updi = n; e_updd = a - st;
            end
            16'b1000_0000_????_????, 16'b1000_0001_????_????: begin
                e_tag = "R9"; e_req = 1; e_we = 1; e_sz = {1'b0, w[8]};
                e_addr = b + 32'(w[3:0]) * (w[8] ? 2 : 1);
                e_wd = msk(z, {1'b0, w[8]});
            end
            16'b1000_0100_????_????, 16'b1000_0101_????_????: begin
                e_tag = "R9"; e_req = 1; e_sz = {1'b0, w[8]}; ld = 1; e_wbi = 0;
                e_addr = b + 32'(w[3:0]) * (w[8] ? 2 : 1);
            end
            16'b0001_????_????_????: begin
                e_tag = "R10"; e_req = 1; e_we = 1; e_sz = 2;
                e_addr = a + 32'(w[3:0]) * 4; e_wd = b;
            end
            16'b0101_????_????_????: begin
                e_tag = "R10"; e_req = 1; e_sz = 2; ld = 1; e_wbi = n;
                e_addr = b + 32'(w[3:0]) * 4;
            end
            16'b0000_????_????_01??: if (s != 3) begin
                e_tag = "R11"; e_req = 1; e_we = 1; e_sz = s;
                e_addr = z + a; e_wd = msk(b, s);
            end
            default: ;
        endcase
        if (ld) begin
            e_wb = 1;
            e_wbd = ext_b(mem_fn(e_addr), e_sz);   // R8
            if (e_tag == "R5" || e_tag == "R7") e_tag = {e_tag, "/R8"};
        end
        e_ill = !(e_wb || e_req);
    endtask

    task automatic check_out(input logic [15:0] w);
        bit bad = 0;
        n_vec++;
        if (illegal !== e_ill || mem_req !== e_req || wb_en !== e_wb ||
            upd_en !== e_upd) bad = 1;
        if (e_req && (mem_we !== e_we || mem_size !== e_sz ||
                      mem_addr !== e_addr || (e_we && mem_wdata !== e_wd))) bad = 1;
        if (e_wb && (wb_idx !== e_wbi || wb_data !== e_wbd)) bad = 1;
        if (e_upd && (upd_idx !== e_updi || upd_data !== e_updd)) bad = 1;
        if (bad) begin
            n_bad++;
            $display("FAIL %s instr=%h act ill%b req%b we%b sz%0d a=%h wd=%h wb%b/%0d=%h up%b/%0d=%h exp ill%b req%b we%b sz%0d a=%h wd=%h wb%b/%0d=%h up%b/%0d=%h",
                e_tag, w, illegal, mem_req, mem_we, mem_size, mem_addr, mem_wdata,
                wb_en, wb_idx, wb_data, upd_en, upd_idx, upd_data,
                e_ill, e_req, e_we, e_sz, e_addr, e_wd, e_wb, e_wbi, e_wbd,
                e_upd, e_updi, e_updd);
        end
    endtask

    task automatic expect_quiet(input string tag);
        n_vec++;
        if (illegal !== 1'b0 || mem_req !== 1'b0 || wb_en !== 1'b0 || upd_en !== 1'b0) begin
            n_bad++;
            $display("FAIL %s quiet: act ill%b req%b wb%b upd%b exp 0000",
                     tag, illegal, mem_req, wb_en, upd_en);
        end
    endtask

    initial begin
        rst = 1'b1; instr_vld = 1'b0; instr = '0; pc = '0;
        fa_data = '0; fb_data = '0; r0_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        expect_quiet("R1 reset");
        rst = 1'b0;
        // R1: idle cycle with valid low
        instr = 16'hE07F;
        @(negedge clk);
        expect_quiet("R1 idle");
        // exhaustive sweep of every word
        for (int i = 0; i < 65536; i++) begin
            logic [31:0] h = 32'(i) * 32'h0101_6F3B ^ 32'hC3A5_0F71;
            if (i > 0) check_out(instr);
            instr     = 16'(i);
            instr_vld = 1'b1;
            pc        = {h[15:0], h[31:17], 1'b0};
            fa_data   = h;
            fb_data   = (instr[11:8] == instr[7:4]) ? h : {h[7:0], h[31:8]} ^ 32'h8000_8001;
            r0_data   = ~{h[23:0], h[31:24]};
            predict(instr, pc, fa_data, fb_data, r0_data);
            @(negedge clk);
        end
        check_out(instr);
        instr_vld = 1'b0;
        @(negedge clk);
        expect_quiet("R1 drain");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule